// File: doc/BRIEF.md
# Unsigned 16x16 Counter-Tree Multiplier

This block is a purely combinational unsigned multiplier. It takes two 16-bit operands and returns their full 32-bit product. It works in three steps. An AND array forms the partial-product bits and files each bit under its weight column. A tree of carry-save stages then compresses every column to two rows. A carry-propagate adder sums those two rows into the final product.

Each carry-save stage splits every column into groups. Each group goes into a binary counter that takes two to seven inputs. A counter with four or more inputs returns a three-bit count of its ones. A counter with two or three inputs returns a two-bit count. The count bits of weight 1, 2 and 4 go to the same column, the next column and the column after that. All counters are built only from full-adder and half-adder cells.

The column height falls from 16 to 9 to 5 to 3. A final carry-save row and a ripple chain of full adders then produce the product. The block has no clock and no storage. The product follows the operands as soon as the logic settles.

Top module: `wallace_mul16`

## Requirements
- R1: For every pair of 16-bit unsigned operands, the 32-bit product output equals their arithmetic product. No carry is lost beyond bit 31 anywhere in the reduction tree.
- R2: If either operand is zero, the product is zero.
- R3: If one operand is 1, the product is the other operand zero-extended to 32 bits.
- R4: If both operands are 16'hFFFF, the product is 32'hFFFE0001.
- R5: Product bit 0 equals the AND of bit 0 of the two operands.
- R6: The product of 2^i and 2^j has only bit i+j set, for every i and j in 0..15.
- R7: Swapping the two operands leaves the product unchanged.
- R8: The block has no clock or reset input. A new pair of operands gives its product with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Multiplicand, unsigned |
| op_b | input | 16 | Multiplier, unsigned |
| product | output | 32 | Unsigned product op_a*op_b |

## Verification
The bound checker watches every change of the operands. On each change it checks four things:
- the product matches the arithmetic product;
- a zero operand gives zero;
- an operand of 1 passes the other operand through;
- product bit 0 is the AND of the two bit-0 inputs.

It also checks that no counter or adder carry leaves the top column. This is an internal fact that the ports alone could never show.

Three properties depend on chosen operands, so only the bench scenarios demonstrate them:
- the full-width corner 16'hFFFF squared;
- the single-bit products that set each column alone;
- the commutation of swapped operands.

The bench also changes the operands several times between clock edges, which shows there is no hidden storage.

// File: rtl/wtm_pkg.sv
`timescale 1ns/1ps
package wtm_pkg;

    parameter int OP_W   = 16;
    parameter int PROD_W = 2 * OP_W;
    parameter int PP_H   = OP_W;

    // group sizes of each carry-save stage (0 = group absent)
    parameter int S1_G0 = 7;
    parameter int S1_G1 = 5;
    parameter int S1_G2 = 4;
    parameter int S2_G0 = 6;
    parameter int S2_G1 = 3;
    parameter int S2_G2 = 0;
    parameter int S3_G0 = 5;
    parameter int S3_G1 = 0;
    parameter int S3_G2 = 0;

    // number of count bits a counter of n inputs returns
    function automatic int ctr_w(input int n);
        if (n == 0) return 0;
        return (n <= 3) ? 2 : 3;
    endfunction

    // first input slot of group g
    function automatic int grp_off(input int g0, input int g1, input int g2, input int g);
        int gs [3];
        int acc;
        gs = '{g0, g1, g2};
        acc = 0;
        for (int k = 0; k < g; k++) acc += gs[k];
        return acc;
    endfunction

    // first output slot of group g
    function automatic int out_base(input int g0, input int g1, input int g2, input int g);
        int gs [3];
        int acc;
        gs = '{g0, g1, g2};
        acc = 0;
        for (int k = 0; k < g; k++) acc += ctr_w(gs[k]);
        return acc;
    endfunction

    // index of group g among the three-output groups
    function automatic int idx3(input int g0, input int g1, input int g2, input int g);
        int gs [3];
        int acc;
        gs = '{g0, g1, g2};
        acc = 0;
        for (int k = 0; k < g; k++) if (ctr_w(gs[k]) == 3) acc++;
        return acc;
    endfunction

    function automatic int n_groups(input int g0, input int g1, input int g2);
        return int'(g0 > 0) + int'(g1 > 0) + int'(g2 > 0);
    endfunction

    function automatic int n_three(input int g0, input int g1, input int g2);
        return int'(ctr_w(g0) == 3) + int'(ctr_w(g1) == 3) + int'(ctr_w(g2) == 3);
    endfunction

    function automatic int stage_h(input int g0, input int g1, input int g2);
        return ctr_w(g0) + ctr_w(g1) + ctr_w(g2);
    endfunction

    parameter int H1 = stage_h(S1_G0, S1_G1, S1_G2);
    parameter int H2 = stage_h(S2_G0, S2_G1, S2_G2);
    parameter int H3 = stage_h(S3_G0, S3_G1, S3_G2);

endpackage

// File: rtl/wtm_cells.sv
`timescale 1ns/1ps
module wtm_ha (
    input  logic x,
    input  logic y,
    output logic s,
    output logic co
);
    assign s  = x ^ y;
    assign co = x & y;
endmodule

module wtm_fa (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ z;
    assign co = (x & y) | (z & (x ^ y));
endmodule

// File: rtl/wtm_ctr.sv
`timescale 1ns/1ps
module wtm_ctr #(
    parameter int N  = 7,
    parameter int OW = wtm_pkg::ctr_w(N)
) (
    input  logic [N-1:0]  bits,
    output logic [OW-1:0] cnt
);
    generate
        if (N == 2) begin : g_n2
            wtm_ha u_h (.x(bits[0]), .y(bits[1]), .s(cnt[0]), .co(cnt[1]));
        end else if (N == 3) begin : g_n3
            wtm_fa u_f (.x(bits[0]), .y(bits[1]), .z(bits[2]), .s(cnt[0]), .co(cnt[1]));
        end else if (N == 4) begin : g_n4
            logic sa, ka, kb;
            wtm_fa u_f0 (.x(bits[0]), .y(bits[1]), .z(bits[2]), .s(sa), .co(ka));
            wtm_ha u_h0 (.x(sa), .y(bits[3]), .s(cnt[0]), .co(kb));
            wtm_ha u_h1 (.x(ka), .y(kb), .s(cnt[1]), .co(cnt[2]));
        end else if (N == 5) begin : g_n5
            logic sa, ka, kb;
            wtm_fa u_f0 (.x(bits[0]), .y(bits[1]), .z(bits[2]), .s(sa), .co(ka));
            wtm_fa u_f1 (.x(sa), .y(bits[3]), .z(bits[4]), .s(cnt[0]), .co(kb));
            wtm_ha u_h0 (.x(ka), .y(kb), .s(cnt[1]), .co(cnt[2]));
        end else if (N == 6) begin : g_n6
            logic sa, sb, ka, kb, kc;
            wtm_fa u_f0 (.x(bits[0]), .y(bits[1]), .z(bits[2]), .s(sa), .co(ka));
            wtm_fa u_f1 (.x(bits[3]), .y(bits[4]), .z(bits[5]), .s(sb), .co(kb));
            wtm_ha u_h0 (.x(sa), .y(sb), .s(cnt[0]), .co(kc));
            wtm_fa u_f2 (.x(ka), .y(kb), .z(kc), .s(cnt[1]), .co(cnt[2]));
        end else begin : g_n7
            logic sa, sb, ka, kb, kc;
            wtm_fa u_f0 (.x(bits[0]), .y(bits[1]), .z(bits[2]), .s(sa), .co(ka));
            wtm_fa u_f1 (.x(bits[3]), .y(bits[4]), .z(bits[5]), .s(sb), .co(kb));
            wtm_fa u_f2 (.x(sa), .y(sb), .z(bits[6]), .s(cnt[0]), .co(kc));
            wtm_fa u_f3 (.x(ka), .y(kb), .z(kc), .s(cnt[1]), .co(cnt[2]));
        end
    endgenerate
endmodule

// File: rtl/wtm_csa_stage.sv
`timescale 1ns/1ps
module wtm_csa_stage
    import wtm_pkg::*;
#(
    parameter int PW = 32,
    parameter int G0 = 7,
    parameter int G1 = 5,
    parameter int G2 = 4,
    parameter int H_IN  = G0 + G1 + G2,
    parameter int H_OUT = stage_h(G0, G1, G2)
) (
    input  logic [PW-1:0][H_IN-1:0]  col_in,
    output logic [PW-1:0][H_OUT-1:0] col_out,
    output logic                     spill
);
    localparam int NG = n_groups(G0, G1, G2);
    localparam int N3 = n_three(G0, G1, G2);
    localparam int GS [3] = '{G0, G1, G2};

    logic [PW-1:0][NG-1:0] s0;
    logic [PW-1:0][NG-1:0] s1;
    logic [PW-1:0][N3-1:0] s2;

    generate
        for (genvar c = 0; c < PW; c++) begin : g_col
            for (genvar g = 0; g < NG; g++) begin : g_grp
                localparam int N   = GS[g];
                localparam int OFF = grp_off(G0, G1, G2, g);
                localparam int OB  = out_base(G0, G1, G2, g);
                localparam int OW  = ctr_w(N);
                localparam int I3  = idx3(G0, G1, G2, g);
                if (OW == 3) begin : g_w3
                    wtm_ctr #(.N(N)) u_ctr (
                        .bits(col_in[c][OFF +: N]),
                        .cnt ({s2[c][I3], s1[c][g], s0[c][g]})
                    );
                    if (c >= 2) begin : g_b2
                        assign col_out[c][OB+2] = s2[c-2][I3];
                    end else begin : g_b2z
                        assign col_out[c][OB+2] = 1'b0;
                    end
                end else begin : g_w2
                    wtm_ctr #(.N(N)) u_ctr (
                        .bits(col_in[c][OFF +: N]),
                        .cnt ({s1[c][g], s0[c][g]})
                    );
                end
                assign col_out[c][OB] = s0[c][g];
                if (c >= 1) begin : g_b1
                    assign col_out[c][OB+1] = s1[c-1][g];
                end else begin : g_b1z
                    assign col_out[c][OB+1] = 1'b0;
                end
            end
        end
    endgenerate

    // count bits whose weight would fall beyond the top column
    assign spill = (|s1[PW-1]) | (|s2[PW-1]) | (|s2[PW-2]);

endmodule

// File: rtl/wtm_cpa.sv
`timescale 1ns/1ps
module wtm_cpa #(
    parameter int PW = 32
) (
    input  logic [PW-1:0][2:0] rows,
    output logic [PW-1:0]      sum,
    output logic               spill
);
    logic [PW-1:0] hs;
    logic [PW-1:0] hk;
    logic [PW-1:0] y;
    logic [PW-1:0] rc;

    generate
        for (genvar c = 0; c < PW; c++) begin : g_row
            wtm_fa u_fa (.x(rows[c][0]), .y(rows[c][1]), .z(rows[c][2]),
                         .s(hs[c]), .co(hk[c]));
        end
    endgenerate

    assign y     = {hk[PW-2:0], 1'b0};
    assign rc[0] = 1'b0;
    assign spill = hk[PW-1];

    generate
        for (genvar i = 0; i < PW - 1; i++) begin : g_rip
            wtm_fa u_fa (.x(hs[i]), .y(y[i]), .z(rc[i]), .s(sum[i]), .co(rc[i+1]));
        end
    endgenerate

    assign sum[PW-1] = hs[PW-1] ^ y[PW-1] ^ rc[PW-1];

endmodule

// File: rtl/wallace_mul16.sv
`timescale 1ns/1ps
module wallace_mul16
    import wtm_pkg::*;
(
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] product
);
    logic [PROD_W-1:0][PP_H-1:0] pp;
    logic [PROD_W-1:0][H1-1:0]   st1;
    logic [PROD_W-1:0][H2-1:0]   st2;
    logic [PROD_W-1:0][H3-1:0]   st3;
    logic spill1, spill2, spill3, spill_cpa;
    logic tree_spill;

    // partial products: slot i of column c holds a[i] & b[c-i]
    generate
        for (genvar c = 0; c < PROD_W; c++) begin : g_ppc
            for (genvar i = 0; i < PP_H; i++) begin : g_ppi
                if ((c - i >= 0) && (c - i < OP_W)) begin : g_on
                    assign pp[c][i] = op_a[i] & op_b[c-i];
                end else begin : g_off
                    assign pp[c][i] = 1'b0;
                end
            end
        end
    endgenerate

    wtm_csa_stage #(.PW(PROD_W), .G0(S1_G0), .G1(S1_G1), .G2(S1_G2)) u_st1 (
        .col_in(pp), .col_out(st1), .spill(spill1)
    );
    wtm_csa_stage #(.PW(PROD_W), .G0(S2_G0), .G1(S2_G1), .G2(S2_G2)) u_st2 (
        .col_in(st1), .col_out(st2), .spill(spill2)
    );
    wtm_csa_stage #(.PW(PROD_W), .G0(S3_G0), .G1(S3_G1), .G2(S3_G2)) u_st3 (
        .col_in(st2), .col_out(st3), .spill(spill3)
    );
    wtm_cpa #(.PW(PROD_W)) u_cpa (
        .rows(st3), .sum(product), .spill(spill_cpa)
    );

    assign tree_spill = spill1 | spill2 | spill3 | spill_cpa;

endmodule

// File: rtl/wallace_mul16_chk.sv
`timescale 1ns/1ps
module wallace_mul16_chk
    import wtm_pkg::*;
(
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] product,
    input logic              tree_spill
);
    logic [PROD_W-1:0] ref_prod;
    assign ref_prod = PROD_W'(op_a) * PROD_W'(op_b);

    always_comb begin
        assert_exact_product_R1: assert (product == ref_prod)
            else $error("R1 product %h expected %h", product, ref_prod);
        assert_no_overflow_R1: assert (!tree_spill)
            else $error("R1 carry left the top column");
        assert_zero_operand_R2: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("R2 zero operand gave %h", product);
        assert_unit_operand_R3: assert (!(op_b == OP_W'(1)) || (product == PROD_W'(op_a)))
            else $error("R3 unit operand gave %h", product);
        assert_lsb_and_R5: assert (product[0] == (op_a[0] & op_b[0]))
            else $error("R5 bit0 mismatch");
    end
endmodule

bind wallace_mul16 wallace_mul16_chk u_chk (
    .op_a(op_a), .op_b(op_b), .product(product), .tree_spill(tree_spill)
);

// File: tb/wallace_mul16_tb_top.sv
`timescale 1ns/1ps
module wallace_mul16_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] p;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    wallace_mul16 dut_i (.op_a(a), .op_b(b), .product(p));

    function automatic logic [31:0] model(input logic [15:0] x, input logic [15:0] y);
        logic [31:0] acc;
        acc = 32'd0;
        for (int k = 0; k < 16; k++) if (y[k]) acc = acc + ({16'd0, x} << k);
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        a = x;
        b = y;
        #1;
    endtask

    task automatic t_initial_zero;   // R2 at start
        apply(16'd0, 16'd0);
        check("R2", p, 32'd0);
    endtask

    task automatic t_zero;           // R2
        apply(16'd0, 16'hFFFF); check("R2", p, 32'd0);
        apply(16'h1234, 16'd0); check("R2", p, 32'd0);
        apply(16'd0, 16'h8001); check("R2", p, 32'd0);
    endtask

    task automatic t_one;            // R3
        apply(16'd1, 16'hBEEF); check("R3", p, 32'h0000BEEF);
        apply(16'hFFFF, 16'd1); check("R3", p, 32'h0000FFFF);
        apply(16'd1, 16'd1);    check("R3", p, 32'd1);
    endtask

    task automatic t_max;            // R4
        apply(16'hFFFF, 16'hFFFF);
        check("R4", p, 32'hFFFE0001);
        apply(16'hFFFF, 16'hFFFE);
        check("R1", p, model(16'hFFFF, 16'hFFFE));
    endtask

    task automatic t_lsb;            // R5
        for (int k = 0; k < 4; k++) begin
            apply(16'h5550 | 16'(k[0]), 16'h3330 | 16'(k[1]));
            check("R5", {31'd0, p[0]}, {31'd0, k[0] & k[1]});
        end
    endtask

    task automatic t_pow2;           // R6
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                apply(16'd1 << i, 16'd1 << j);
                check("R6", p, 32'd1 << (i + j));
            end
        end
    endtask

    task automatic t_swap;           // R7
        logic [31:0] first;
        apply(16'hA5C3, 16'h0F7E); first = p;
        apply(16'h0F7E, 16'hA5C3); check("R7", p, first);
        apply(16'h8000, 16'hFFFF); first = p;
        apply(16'hFFFF, 16'h8000); check("R7", p, first);
    endtask

    task automatic t_no_clock;       // R8: several operand changes inside one clock phase
        @(posedge clk);
        #1;
        a = 16'h00FF; b = 16'h0101; #0.5;
        check("R8", p, model(16'h00FF, 16'h0101));
        a = 16'hF00D; b = 16'h0003; #0.5;
        check("R8", p, model(16'hF00D, 16'h0003));
        a = 16'h7FFF; b = 16'h7FFF; #0.5;
        check("R8", p, model(16'h7FFF, 16'h7FFF));
    endtask

    task automatic t_random;         // R1
        logic [31:0] st;
        st = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            st = st ^ (st << 13);
            st = st ^ (st >> 17);
            st = st ^ (st << 5);
            apply(st[15:0], st[31:16]);
            check("R1", p, model(st[15:0], st[31:16]));
        end
    endtask

    task automatic t_dense;          // R1: long carry chains
        apply(16'hAAAA, 16'h5555); check("R1", p, model(16'hAAAA, 16'h5555));
        apply(16'hFFFF, 16'h0001); check("R1", p, 32'h0000FFFF);
        apply(16'h8000, 16'h8000); check("R1", p, 32'h40000000);
        apply(16'hFF00, 16'h00FF); check("R1", p, model(16'hFF00, 16'h00FF));
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        a = 16'd0;
        b = 16'd0;
        t_initial_zero();
        t_zero();
        t_one();
        t_max();
        t_lsb();
        t_pow2();
        t_swap();
        t_no_clock();
        t_dense();
        t_random();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

endmodule